// File: doc/BRIEF.md
# Destination Address Filter with Station Table

This block screens received Ethernet frames by their 48-bit destination address. The address arrives one byte per strobe, first byte first. One clock after the sixth byte the block gives a registered verdict: accept or reject, plus a flag that says whether the frame was taken as multicast or as broadcast. Three mode inputs widen the filter: promiscuous unicast, all-multicast and broadcast. After those modes, the block compares the address against a 16-entry station table. A 16-bit enable mask selects which table entries take part in the compare.

Software fills the table through a loader that reads a word stream. A load command carries a 5-bit entry count. The loader takes three 16-bit words for each entry and then one final word, which becomes the enable mask. When the mask word has been taken, the loader drops its busy flag and sets a sticky done flag. A readback path exposes one table entry as three 16-bit words. It does so only while the surrounding controller reports that it is in reset, and returns zeros at all other times.

Top module: `da_filter`

## Requirements
- R1: `verdict_vld` pulses high for one cycle, in the cycle after the clock edge that captured the sixth address byte. `addr_sof` marks a byte as byte 0 of a new address and discards any partial address. Byte k is the k-th byte received, and bit 0 of byte 0 is the group (multicast) bit.
- R2: With `mode_promisc` set, an address whose group bit is 0 is accepted with both type flags low. This check has the highest priority.
- R3: With `mode_all_mcast` set, an address whose group bit is 1 is accepted with `verdict_mcast` high. This check takes priority over broadcast, so the all-ones address gives the multicast flag in this mode.
- R4: With `mode_bcast` set, and when no earlier check decided, the all-ones address is accepted with `verdict_bcast` high.
- R5: When no mode check decides, the frame is accepted with no flag only if it exactly matches a table entry whose enable-mask bit (bit i for entry i) is 1. Otherwise it is rejected with both flags low. A frame that no check accepts is rejected in every mode.
- R6: Each entry is loaded from three words, and word w supplies address bytes 2w (low half) and 2w+1 (high half).
- R7: A load with count N writes N entries to indices 0, 1, 2, and so on, wrapping modulo 16, and then takes one word as the enable mask. A count of 0 takes only the mask word.
- R8: `load_busy` is high from the edge after `load_start` until the mask word is taken. At that edge `load_done` rises. `load_done` stays high until `load_done_ack` is applied.
- R9: A `load_start` that arrives while the loader is busy is ignored.
- R10: While `ctl_in_reset` is high, `cam_rd_wordK` (K = 0, 1, 2) returns bytes 2K (low half) and 2K+1 (high half) of the entry selected by `cam_rd_ptr`. While `ctl_in_reset` is low, all three ports read as zero.
- R11: Hardware reset clears the enable mask, so no table entry matches after reset. It also clears `verdict_vld`, `load_busy` and `load_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_in_reset | input | 1 | Controller is in reset mode; enables readback |
| mode_promisc | input | 1 | Accept all unicast addresses |
| mode_all_mcast | input | 1 | Accept all group addresses |
| mode_bcast | input | 1 | Accept the broadcast address |
| addr_vld | input | 1 | Address byte strobe |
| addr_sof | input | 1 | Marks the strobed byte as byte 0 |
| addr_byte | input | 8 | Address byte |
| verdict_vld | output | 1 | Verdict valid pulse |
| verdict_accept | output | 1 | Frame accepted |
| verdict_mcast | output | 1 | Accepted as multicast |
| verdict_bcast | output | 1 | Accepted as broadcast |
| load_start | input | 1 | Start a table load |
| load_count | input | 5 | Number of entries to load |
| load_word_vld | input | 1 | Load word strobe |
| load_word | input | 16 | Load word |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Sticky load-complete status |
| load_done_ack | input | 1 | Clears `load_done` |
| cam_rd_ptr | input | 4 | Readback entry pointer |
| cam_rd_word0 | output | 16 | Readback bytes 0 and 1 |
| cam_rd_word1 | output | 16 | Readback bytes 2 and 3 |
| cam_rd_word2 | output | 16 | Readback bytes 4 and 5 |

## Verification
The bench targets the priority overlaps, and for each one it shows what a broken design would do:
- The broadcast address with all-multicast on must carry the multicast flag. A design that tested broadcast first would report the broadcast flag instead.
- A table hit on a disabled entry must reject the frame. A design that ignored the mask would accept it.
- A load count above 16 must wrap the entry index. A design that did not wrap would write entries outside the table.
- A count of 0 must take only the mask word.
- A second load command in mid-load must be ignored. A design that restarted on it would stay busy after the mask word.
- A restart of the address with `addr_sof` must give no verdict until six bytes of the new address have arrived. A design that kept the partial address would give the verdict too early.
- After reset the mask must be clear, so a table that still holds its contents can no longer hit.

// File: rtl/da_filter_pkg.sv
// Package: shared widths, loader state encoding and verdict type for the
// destination address filter.
package da_filter_pkg;
    localparam int MAC_BYTES       = 6;
    localparam int MAC_W           = 8 * MAC_BYTES;
    localparam int WORD_W          = 16;
    localparam int WORDS_PER_ENTRY = MAC_W / WORD_W;

    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ENTRY = 2'd1,
        LD_MASK  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic accept;
        logic mcast;
        logic bcast;
    } verdict_t;
endpackage

// File: rtl/da_cam_store.sv
// Module: da_cam_store
// Holds the station table and its enable mask, and produces a hit for the
// address under test. It also drives the gated readback words.
// Assumes: ENTRIES <= WORD_W, because the mask is loaded from one word.
// Table contents have no reset; the mask resets to zero.
module da_cam_store
    import da_filter_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PTR_W   = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [PTR_W-1:0]                 wr_idx,
    input  mac_t                             wr_entry,
    input  logic                             mask_we,
    input  logic [ENTRIES-1:0]               mask_in,
    input  mac_t                             look_addr,
    output logic                             hit,
    input  logic [PTR_W-1:0]                 rd_ptr,
    input  logic                             rd_allow,
    output logic [WORDS_PER_ENTRY*WORD_W-1:0] rd_flat
);
    mac_t               tbl [ENTRIES];
    logic [ENTRIES-1:0] en_mask;
    logic [ENTRIES-1:0] hit_vec;

    // Table write port, driven by the loader.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tbl[wr_idx] <= wr_entry;
        end
    end

    // Enable mask register, cleared by hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else if (mask_we) begin
            en_mask <= mask_in;
        end
    end

    // One comparator per entry, each qualified by its mask bit.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = en_mask[i] && (tbl[i] == look_addr);
    end

    // Any enabled exact match counts as a hit.
    always_comb begin
        hit = |hit_vec;
    end

    // Readback words, forced to zero outside reset mode.
    for (genvar k = 0; k < WORDS_PER_ENTRY; k++) begin : g_rd
        assign rd_flat[k*WORD_W +: WORD_W] =
            rd_allow ? tbl[rd_ptr][k*WORD_W +: WORD_W] : '0;
    end
endmodule

// File: rtl/da_cam_loader.sv
// Module: da_cam_loader
// Fills the table from a word stream: three words per entry while the count
// is nonzero, then one word as the enable mask.
// Assumes: the word stream follows the start command; a start command during
// a load is ignored.
module da_cam_loader
    import da_filter_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PTR_W   = $clog2(ENTRIES),
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   count_in,
    input  logic               word_vld,
    input  logic [WORD_W-1:0]  word,
    input  logic               done_ack,
    output logic               busy,
    output logic               done,
    output logic               wr_en,
    output logic [PTR_W-1:0]   wr_idx,
    output mac_t               wr_entry,
    output logic               mask_we,
    output logic [ENTRIES-1:0] mask_out
);
    localparam int ACC_W   = (WORDS_PER_ENTRY - 1) * WORD_W;
    localparam int WSEL_W  = $clog2(WORDS_PER_ENTRY);
    localparam logic [WSEL_W-1:0] WSEL_LAST = WSEL_W'(WORDS_PER_ENTRY - 1);

    ld_state_e          st;
    logic [CNT_W-1:0]   remain;
    logic [WSEL_W-1:0]  wsel;
    logic [ACC_W-1:0]   acc;

    // Sequencer: idle, then entry words, then the mask word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= LD_IDLE;
            remain <= '0;
            wsel   <= '0;
            wr_idx <= '0;
            acc    <= '0;
        end else begin
            case (st)
                LD_IDLE: begin
                    if (start) begin
                        remain <= count_in;
                        wsel   <= '0;
                        wr_idx <= '0;
                        st     <= (count_in == '0) ? LD_MASK : LD_ENTRY;
                    end
                end
                LD_ENTRY: begin
                    if (word_vld) begin
                        if (wsel == WSEL_LAST) begin
                            wsel   <= '0;
                            wr_idx <= wr_idx + PTR_W'(1);
                            remain <= remain - CNT_W'(1);
                            if (remain == CNT_W'(1)) begin
                                st <= LD_MASK;
                            end
                        end else begin
                            acc[wsel*WORD_W +: WORD_W] <= word;
                            wsel <= wsel + WSEL_W'(1);
                        end
                    end
                end
                LD_MASK: begin
                    if (word_vld) begin
                        st <= LD_IDLE;
                    end
                end
                default: st <= LD_IDLE;
            endcase
        end
    end

    // Sticky completion flag: set when the mask is taken, cleared on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (mask_we) begin
            done <= 1'b1;
        end else if (done_ack) begin
            done <= 1'b0;
        end
    end

    // Write strobes and data toward the table.
    always_comb begin
        busy     = (st != LD_IDLE);
        wr_en    = (st == LD_ENTRY) && word_vld && (wsel == WSEL_LAST);
        wr_entry = {word, acc};
        mask_we  = (st == LD_MASK) && word_vld;
        mask_out = word[ENTRIES-1:0];
    end
endmodule

// File: rtl/da_match_decide.sv
// Module: da_match_decide
// Assembles the address bytes and applies the mode checks in priority order
// ahead of the table hit. The verdict is registered on the sixth byte.
// Assumes: the table hit for look_addr arrives combinationally.
module da_match_decide
    import da_filter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic       sof,
    input  logic [7:0] byte_in,
    input  logic       promisc,
    input  logic       all_mcast,
    input  logic       bcast_en,
    output mac_t       look_addr,
    input  logic       cam_hit,
    output logic       dec_vld,
    output verdict_t   verdict
);
    localparam int POS_W = $clog2(MAC_BYTES);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(MAC_BYTES - 1);

    logic [MAC_W-9:0]  collected;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  cur_pos;
    logic              last;
    verdict_t          nxt;

    // Position of the current byte; a start-of-address byte is byte 0.
    always_comb begin
        cur_pos   = sof ? '0 : pos;
        last      = byte_vld && (cur_pos == POS_LAST);
        look_addr = {byte_in, collected};
    end

    // Byte collection and position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos       <= '0;
            collected <= '0;
        end else if (byte_vld) begin
            if (!last) begin
                collected[{cur_pos, 3'b000} +: 8] <= byte_in;
            end
            pos <= last ? '0 : cur_pos + POS_W'(1);
        end
    end

    // Priority: promiscuous, all-multicast, broadcast, then the table.
    always_comb begin
        nxt = '0;
        if (promisc && !look_addr[0]) begin
            nxt.accept = 1'b1;
        end else if (all_mcast && look_addr[0]) begin
            nxt.accept = 1'b1;
            nxt.mcast  = 1'b1;
        end else if (bcast_en && (&look_addr)) begin
            nxt.accept = 1'b1;
            nxt.bcast  = 1'b1;
        end else if (cam_hit) begin
            nxt.accept = 1'b1;
        end
    end

    // Registered verdict and one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld <= 1'b0;
            verdict <= '0;
        end else begin
            dec_vld <= last;
            if (last) begin
                verdict <= nxt;
            end
        end
    end
endmodule

// File: rtl/da_filter.sv
// Module: da_filter (top)
// Destination address filter: ties the byte decider, the station table and
// the table loader together.
// Assumes: ctl_in_reset comes from the controller's command state.
module da_filter
    import da_filter_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PTR_W   = $clog2(ENTRIES),
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_in_reset,
    input  logic               mode_promisc,
    input  logic               mode_all_mcast,
    input  logic               mode_bcast,
    input  logic               addr_vld,
    input  logic               addr_sof,
    input  logic [7:0]         addr_byte,
    output logic               verdict_vld,
    output logic               verdict_accept,
    output logic               verdict_mcast,
    output logic               verdict_bcast,
    input  logic               load_start,
    input  logic [CNT_W-1:0]   load_count,
    input  logic               load_word_vld,
    input  logic [WORD_W-1:0]  load_word,
    output logic               load_busy,
    output logic               load_done,
    input  logic               load_done_ack,
    input  logic [PTR_W-1:0]   cam_rd_ptr,
    output logic [WORD_W-1:0]  cam_rd_word0,
    output logic [WORD_W-1:0]  cam_rd_word1,
    output logic [WORD_W-1:0]  cam_rd_word2
);
    mac_t                              look_addr;
    logic                              cam_hit;
    logic                              wr_en;
    logic [PTR_W-1:0]                  wr_idx;
    mac_t                              wr_entry;
    logic                              mask_we;
    logic [ENTRIES-1:0]                mask_val;
    logic [WORDS_PER_ENTRY*WORD_W-1:0] rd_flat;
    verdict_t                          verdict;

    da_match_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (addr_vld),
        .sof       (addr_sof),
        .byte_in   (addr_byte),
        .promisc   (mode_promisc),
        .all_mcast (mode_all_mcast),
        .bcast_en  (mode_bcast),
        .look_addr (look_addr),
        .cam_hit   (cam_hit),
        .dec_vld   (verdict_vld),
        .verdict   (verdict)
    );

    da_cam_store #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry),
        .mask_we   (mask_we),
        .mask_in   (mask_val),
        .look_addr (look_addr),
        .hit       (cam_hit),
        .rd_ptr    (cam_rd_ptr),
        .rd_allow  (ctl_in_reset),
        .rd_flat   (rd_flat)
    );

    da_cam_loader #(.ENTRIES(ENTRIES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (load_start),
        .count_in (load_count),
        .word_vld (load_word_vld),
        .word     (load_word),
        .done_ack (load_done_ack),
        .busy     (load_busy),
        .done     (load_done),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .mask_we  (mask_we),
        .mask_out (mask_val)
    );

    // Unpack the verdict and the readback words onto the ports.
    always_comb begin
        verdict_accept = verdict.accept;
        verdict_mcast  = verdict.mcast;
        verdict_bcast  = verdict.bcast;
        cam_rd_word0   = rd_flat[0*WORD_W +: WORD_W];
        cam_rd_word1   = rd_flat[1*WORD_W +: WORD_W];
        cam_rd_word2   = rd_flat[2*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/da_filter_chk.sv
// Module: da_filter_chk
// Temporal checks on the filter's ports, attached to every da_filter
// instance by the bind statement at the end of this file.
module da_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_in_reset,
    input logic        addr_vld,
    input logic        verdict_vld,
    input logic        verdict_accept,
    input logic        verdict_mcast,
    input logic        verdict_bcast,
    input logic        load_start,
    input logic        load_word_vld,
    input logic        load_busy,
    input logic        load_done,
    input logic [15:0] cam_rd_word0,
    input logic [15:0] cam_rd_word1,
    input logic [15:0] cam_rd_word2
);
    // R1: a verdict pulse only follows a byte strobe.
    a_r1_vld_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld |-> $past(addr_vld));

    // R3, R4: a type flag implies acceptance, and the two flags never show together.
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld |-> !(verdict_mcast && verdict_bcast)
                        && ((verdict_mcast || verdict_bcast) ? verdict_accept : 1'b1));

    // R8: busy falling always comes with done set.
    a_r8_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_busy) |-> load_done);

    // R9: a start while busy, with no word taken, leaves the loader busy.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (load_busy && load_start && !load_word_vld) |=> load_busy);

    // R10: readback is zero outside reset mode.
    a_r10_rd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_in_reset |-> (cam_rd_word0 == 16'h0 && cam_rd_word1 == 16'h0
                           && cam_rd_word2 == 16'h0));
endmodule

bind da_filter da_filter_chk u_chk (.*);

// File: tb/da_filter_test.sv
`timescale 1ns/1ps
// Bench for da_filter: directed corner cases plus seeded random frames,
// checked against a reference model kept in the bench.
module da_filter_test;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_in_reset = 1'b0;
    logic        mode_promisc = 1'b0, mode_all_mcast = 1'b0, mode_bcast = 1'b0;
    logic        addr_vld = 1'b0, addr_sof = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        verdict_vld, verdict_accept, verdict_mcast, verdict_bcast;
    logic        load_start = 1'b0;
    logic [4:0]  load_count = '0;
    logic        load_word_vld = 1'b0;
    logic [15:0] load_word = '0;
    logic        load_busy, load_done;
    logic        load_done_ack = 1'b0;
    logic [3:0]  cam_rd_ptr = '0;
    logic [15:0] cam_rd_word0, cam_rd_word1, cam_rd_word2;

    int n_checks = 0;
    int n_errors = 0;
    logic [47:0] cam_ref [16];
    logic [15:0] mask_ref = '0;

    da_filter uut (.*);

    always #(CLK_P/2) clk = ~clk;

    // Records one check and prints a FAIL line when it does not hold.
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference verdict {accept, mcast, bcast}.
    function automatic logic [2:0] ref_dec(input logic [47:0] a, input logic p,
                                           input logic am, input logic b);
        if (p && !a[0]) return 3'b100;
        if (am && a[0]) return 3'b110;
        if (b && (&a)) return 3'b101;
        for (int i = 0; i < 16; i++)
            if (mask_ref[i] && cam_ref[i] == a) return 3'b100;
        return 3'b000;
    endfunction

    // Sends six bytes and samples the verdict in the following cycle.
    task automatic send_frame(input logic [47:0] a, output logic vld,
                              output logic [2:0] got);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr_vld = 1'b1; addr_sof = (k == 0); addr_byte = a[8*k +: 8];
        end
        @(negedge clk);
        addr_vld = 1'b0; addr_sof = 1'b0;
        vld = verdict_vld;
        got = {verdict_accept, verdict_mcast, verdict_bcast};
    endtask

    // Sends a frame and compares the verdict with the model.
    task automatic frame_chk(input logic [47:0] a, input string req);
        logic v; logic [2:0] g, e;
        e = ref_dec(a, mode_promisc, mode_all_mcast, mode_bcast);
        send_frame(a, v, g);
        chk(v == 1'b1 && g == e, req, "verdict {vld,acc,mc,bc}", {v, g}, {1'b1, e});
    endtask

    // Pushes one load word, with an optional idle cycle before it.
    task automatic push_word(input logic [15:0] w, input bit gap);
        if (gap) @(negedge clk);
        @(negedge clk);
        load_word_vld = 1'b1; load_word = w;
        @(negedge clk);
        load_word_vld = 1'b0;
    endtask

    // Runs a full load and updates the model.
    task automatic load_table(input int cnt, input logic [15:0] mask, input bit gaps);
        logic [47:0] ent;
        @(negedge clk);
        load_start = 1'b1; load_count = 5'(cnt);
        @(negedge clk);
        load_start = 1'b0;
        for (int e = 0; e < cnt; e++) begin
            ent = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
            cam_ref[e % 16] = ent;
            for (int w = 0; w < 3; w++) push_word(ent[16*w +: 16], gaps && $urandom_range(1) == 1);
        end
        push_word(mask, gaps);
        mask_ref = mask;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_P * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic v; logic [2:0] g;
        logic [47:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) cam_ref[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!verdict_vld && !load_busy && !load_done, "R11", "reset outputs",
            {verdict_vld, load_busy, load_done}, 3'b000);

        // R7, R6: a count of 17 wraps the index; readback checks the byte layout
        load_table(17, 16'hFFFF, 1'b0);
        chk(!load_busy && load_done, "R8", "busy/done after load", {load_busy, load_done}, 2'b01);
        @(negedge clk); load_done_ack = 1'b1; @(negedge clk); load_done_ack = 1'b0;
        chk(!load_done, "R8", "done cleared by ack", load_done, 0);
        ctl_in_reset = 1'b1;
        for (int p = 0; p < 16; p++) begin
            cam_rd_ptr = 4'(p); #1;
            chk({cam_rd_word2, cam_rd_word1, cam_rd_word0} == cam_ref[p], "R10",
                "readback entry (R6 R7 wrap)", {cam_rd_word2, cam_rd_word1, cam_rd_word0}, cam_ref[p]);
        end
        ctl_in_reset = 1'b0; #1;
        chk(cam_rd_word0 == 0 && cam_rd_word1 == 0 && cam_rd_word2 == 0, "R10",
            "readback outside reset", {cam_rd_word2, cam_rd_word1, cam_rd_word0}, 0);

        // R5: an enabled entry hits; the same entry disabled misses
        frame_chk(cam_ref[3], "R5");
        @(negedge clk); load_start = 1'b1; load_count = 5'd0;
        @(negedge clk); load_start = 1'b0;
        push_word(16'hFFF7, 1'b0); mask_ref = 16'hFFF7;
        chk(!load_busy, "R7", "count 0 takes only the mask", load_busy, 0);
        frame_chk(cam_ref[3], "R5");
        frame_chk(cam_ref[4], "R5");

        // R3 over R4: the broadcast address with all-multicast on
        mode_all_mcast = 1'b1; mode_bcast = 1'b1;
        frame_chk(48'hFFFF_FFFF_FFFF, "R3");
        mode_all_mcast = 1'b0;
        frame_chk(48'hFFFF_FFFF_FFFF, "R4");
        frame_chk(48'h1234_5678_9A01, "R5");
        mode_bcast = 1'b0;
        // R2: promiscuous accepts unicast, not group
        mode_promisc = 1'b1;
        frame_chk(48'h0000_0000_0A02, "R2");
        frame_chk(48'h0000_0000_0A03, "R2");
        mode_promisc = 1'b0;

        // R1: a partial address restarted by addr_sof
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); addr_vld = 1'b1; addr_sof = (k == 0); addr_byte = 8'hEE;
        end
        a = cam_ref[5];
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); addr_vld = 1'b1; addr_sof = (k == 0); addr_byte = a[8*k +: 8];
            if (k == 5) chk(!verdict_vld, "R1", "no early verdict after sof", verdict_vld, 0);
        end
        @(negedge clk); addr_vld = 1'b0; addr_sof = 1'b0;
        chk(verdict_vld && verdict_accept, "R1", "verdict after restart",
            {verdict_vld, verdict_accept}, 2'b11);
        @(negedge clk);
        chk(!verdict_vld, "R1", "single-cycle pulse", verdict_vld, 0);

        // R9: a start during a load is ignored
        @(negedge clk); load_start = 1'b1; load_count = 5'd1;
        @(negedge clk); load_start = 1'b0;
        a = 48'hA1B2_C3D4_E5F6;
        push_word(a[15:0], 1'b0);
        @(negedge clk); load_start = 1'b1; load_count = 5'd5;
        @(negedge clk); load_start = 1'b0;
        push_word(a[31:16], 1'b0);
        push_word(a[47:32], 1'b0);
        push_word(16'h0001, 1'b0);
        cam_ref[0] = a; mask_ref = 16'h0001;
        chk(!load_busy && load_done, "R9", "mid-load start ignored", {load_busy, load_done}, 2'b01);
        frame_chk(a, "R9");

        // Random frames mixed with random loads
        for (int n = 0; n < 300; n++) begin
            if (n % 75 == 74) load_table($urandom_range(20), 16'($urandom), 1'b1);
            mode_promisc = ($urandom_range(3) == 0);
            mode_all_mcast = ($urandom_range(3) == 0);
            mode_bcast = ($urandom_range(1) == 1);
            case ($urandom_range(3))
                0: a = {$urandom, $urandom};
                1: a = cam_ref[$urandom_range(15)];
                2: a = 48'hFFFF_FFFF_FFFF;
                default: a = {$urandom, $urandom} | 48'h1;
            endcase
            frame_chk(a, "R5");
        end
        mode_promisc = 1'b0; mode_all_mcast = 1'b0; mode_bcast = 1'b0;

        // R11: reset clears the mask while the table keeps its contents
        load_table(2, 16'h0003, 1'b0);
        a = cam_ref[1];
        frame_chk(a, "R5");
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        mask_ref = '0;
        send_frame(a, v, g);
        chk(v && g == 3'b000, "R11", "no hit after reset", {v, g}, 4'b1000);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule